// File: doc/BRIEF.md
# Page Translation Cache

This block is a small fully associative cache of recent page translations that sits between address generation and the page table walker. It holds a fixed set of entries. Each entry maps a 20-bit linear page number to a 20-bit physical frame number and records three page attributes: writable, user-accessible and dirty. Pages are 4 KB, so the default 32 entries span 128 KB of linear space.

A lookup presents a 32-bit linear address, an access kind (read or write) and the current privilege (user or supervisor). Upper address bits 31:12 are compared against every valid entry in parallel. In the same cycle the block reports a hit with the translated address, a miss that asks the walker for that page, or a protection fault. A write to a clean page is reported as a miss so that the walker can set the page's dirty flag and refill the entry. The walker returns its result on a fill port. Writing the page directory base register pulses a flush input, which empties the whole cache.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, so every lookup reports a miss and `physAddr` is zero.
- R2: A lookup that hits and passes the checks raises `lookupHit` in the same cycle, with `physAddr` equal to the stored frame number in bits 31:12 and `linAddr[11:0]` in bits 11:0.
- R3: A lookup whose page number matches no valid entry raises `lookupMiss` in the same cycle, with `walkVpn` equal to `linAddr[31:12]` and `physAddr` zero.
- R4: A fill written on one clock edge is visible to lookups from the next cycle onward.
- R5: A `flushDir` pulse invalidates every entry from the next cycle onward. A fill presented in the same cycle as the flush is discarded.
- R6: A write lookup that hits an entry whose dirty attribute is 0 reports `lookupMiss`, not a hit, whatever the privilege.
- R7: In user mode (`userMode`=1), a hit on an entry with user attribute 0 raises `protFault`. So does a write hit on an entry with writable attribute 0. In supervisor mode both attributes are ignored. A fault takes precedence over the dirty rule in R6, and `physAddr` is zero during a fault.
- R8: A fill whose page number already sits in a valid entry overwrites that entry, so no page number is ever held twice.
- R9: A fill of a new page number uses the lowest-numbered invalid entry. When every entry is valid, it replaces the entry at a round-robin pointer. The pointer starts at 0 after reset and advances by one after each such replacement.
- R10: When `lookupValid` is 0, `lookupHit`, `lookupMiss` and `protFault` are all 0, and at most one of them is ever 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | A lookup is presented this cycle |
| linAddr | input | 32 | Linear address to translate |
| isWrite | input | 1 | Lookup is a write access |
| userMode | input | 1 | Access comes from user privilege |
| lookupHit | output | 1 | Translation found and permitted |
| lookupMiss | output | 1 | Walker must supply this page |
| protFault | output | 1 | Cached attributes forbid the access |
| physAddr | output | 32 | Translated address, zero unless hit |
| attrRw | output | 1 | Writable attribute of the hit entry |
| attrUs | output | 1 | User attribute of the hit entry |
| attrDirty | output | 1 | Dirty attribute of the hit entry |
| walkVpn | output | 20 | Page number the walker is asked for |
| fillValid | input | 1 | Walker result is presented |
| fillVpn | input | 20 | Page number of the walker result |
| fillPfn | input | 20 | Frame number of the walker result |
| fillRw | input | 1 | Writable attribute of the walker result |
| fillUs | input | 1 | User attribute of the walker result |
| fillDirty | input | 1 | Dirty attribute of the walker result |
| flushDir | input | 1 | Directory base register was written |

## Verification
All lookup results (hit, miss, fault, address, attributes, walker page number) are combinational and due in the same cycle as the lookup. The bench therefore drives each lookup just after a falling edge and samples one nanosecond later, before the next rising edge. Fills and flushes take effect at the rising edge after they are driven, so the bench always checks their effect with a lookup in a later cycle and never in the cycle that carries them. The eviction order is checked at the ports by filling the cache past its capacity and then looking up which pages survive.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef struct packed {
    logic rw;
    logic us;
    logic dirty;
  } pageAttr_t;

  typedef struct packed {
    logic fillEn;
    logic flushAll;
  } ctrlStrobe_t;
endpackage

// File: rtl/xlat_dp.sv
module xlat_dp
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [IDX_W-1:0]   fillIdx,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic [PFN_W-1:0]   fillPfn,
  input  pageAttr_t          fillAttr,
  input  logic [VPN_W-1:0]   lookVpn,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] fillMatchVec,
  output logic               hitAny,
  output logic [PFN_W-1:0]   hitPfn,
  output pageAttr_t          hitAttr
);
  logic [VPN_W-1:0]   vpnMem  [ENTRIES];
  logic [PFN_W-1:0]   pfnMem  [ENTRIES];
  pageAttr_t          attrMem [ENTRIES];
  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] lookMatchVec;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flushAll) begin
      validQ <= '0;
    end else if (strobe.fillEn) begin
      validQ[fillIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillEn && !strobe.flushAll) begin
      vpnMem[fillIdx]  <= fillVpn;
      pfnMem[fillIdx]  <= fillPfn;
      attrMem[fillIdx] <= fillAttr;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lookMatchVec[g] = validQ[g] && (vpnMem[g] == lookVpn);
    assign fillMatchVec[g] = validQ[g] && (vpnMem[g] == fillVpn);
  end

  always_comb begin
    hitPfn  = '0;
    hitAttr = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lookMatchVec[i]) begin
        hitPfn  = hitPfn | pfnMem[i];
        hitAttr = hitAttr | attrMem[i];
      end
    end
  end

  assign hitAny   = |lookMatchVec;
  assign validVec = validQ;
endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic               isWrite,
  input  logic               userMode,
  input  logic               hitAny,
  input  pageAttr_t          hitAttr,
  input  logic               fillValid,
  input  logic               flushDir,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] fillMatchVec,
  output ctrlStrobe_t        strobe,
  output logic [IDX_W-1:0]   fillIdx,
  output logic               lookupHit,
  output logic               lookupMiss,
  output logic               protFault
);
  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] dupIdx;
  logic [IDX_W-1:0] freeIdx;
  logic             freeAny;
  logic             dupAny;
  logic             replaceUse;
  logic             permBad;
  logic             cleanWrite;

  assign permBad    = userMode && (!hitAttr.us || (isWrite && !hitAttr.rw));
  assign cleanWrite = isWrite && !hitAttr.dirty;
  assign protFault  = lookupValid && hitAny && permBad;
  assign lookupHit  = lookupValid && hitAny && !permBad && !cleanWrite;
  assign lookupMiss = lookupValid && (!hitAny || (!permBad && cleanWrite));

  always_comb begin
    freeIdx = '0;
    freeAny = 1'b0;
    dupIdx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        freeIdx = IDX_W'(i);
        freeAny = 1'b1;
      end
      if (fillMatchVec[i]) begin
        dupIdx = IDX_W'(i);
      end
    end
  end

  assign dupAny     = |fillMatchVec;
  assign replaceUse = !dupAny && !freeAny;

  always_comb begin
    if (dupAny)       fillIdx = dupIdx;
    else if (freeAny) fillIdx = freeIdx;
    else              fillIdx = rrPtr;
  end

  assign strobe.flushAll = flushDir;
  assign strobe.fillEn   = fillValid && !flushDir;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (strobe.fillEn && replaceUse) begin
      rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 12,
  localparam int VPN_W  = ADDR_W - OFF_W,
  localparam int PFN_W  = ADDR_W - OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] linAddr,
  input  logic              isWrite,
  input  logic              userMode,
  output logic              lookupHit,
  output logic              lookupMiss,
  output logic              protFault,
  output logic [ADDR_W-1:0] physAddr,
  output logic              attrRw,
  output logic              attrUs,
  output logic              attrDirty,
  output logic [VPN_W-1:0]  walkVpn,
  input  logic              fillValid,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PFN_W-1:0]  fillPfn,
  input  logic              fillRw,
  input  logic              fillUs,
  input  logic              fillDirty,
  input  logic              flushDir
);
  ctrlStrobe_t        strobe;
  logic [IDX_W-1:0]   fillIdx;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] fillMatchVec;
  logic               hitAny;
  logic [PFN_W-1:0]   hitPfn;
  pageAttr_t          hitAttr;
  pageAttr_t          fillAttr;

  assign fillAttr = '{rw: fillRw, us: fillUs, dirty: fillDirty};

  xlat_dp #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fillIdx(fillIdx),
    .fillVpn(fillVpn), .fillPfn(fillPfn), .fillAttr(fillAttr),
    .lookVpn(linAddr[ADDR_W-1:OFF_W]), .validVec(validVec),
    .fillMatchVec(fillMatchVec), .hitAny(hitAny), .hitPfn(hitPfn),
    .hitAttr(hitAttr)
  );

  xlat_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .isWrite(isWrite),
    .userMode(userMode), .hitAny(hitAny), .hitAttr(hitAttr),
    .fillValid(fillValid), .flushDir(flushDir), .validVec(validVec),
    .fillMatchVec(fillMatchVec), .strobe(strobe), .fillIdx(fillIdx),
    .lookupHit(lookupHit), .lookupMiss(lookupMiss), .protFault(protFault)
  );

  assign physAddr  = lookupHit ? {hitPfn, linAddr[OFF_W-1:0]} : '0;
  assign attrRw    = lookupHit && hitAttr.rw;
  assign attrUs    = lookupHit && hitAttr.us;
  assign attrDirty = lookupHit && hitAttr.dirty;
  assign walkVpn   = linAddr[ADDR_W-1:OFF_W];
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              lookupValid,
  input logic [ADDR_W-1:0] linAddr,
  input logic              isWrite,
  input logic              userMode,
  input logic              flushDir,
  input logic              lookupHit,
  input logic              lookupMiss,
  input logic              protFault,
  input logic [ADDR_W-1:0] physAddr,
  input logic              attrDirty
);
  // R10
  idle_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> !(lookupHit || lookupMiss || protFault));

  // R10
  one_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({lookupHit, lookupMiss, protFault}));

  // R5
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushDir |=> !lookupHit);

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupHit |-> physAddr[OFF_W-1:0] == linAddr[OFF_W-1:0]);

  // R7
  fault_user_chk: assert property (@(posedge clk) disable iff (!rstN)
    protFault |-> userMode && physAddr == '0);

  // R6
  clean_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupHit && isWrite |-> attrDirty);

  // R3
  miss_noaddr_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupMiss |-> physAddr == '0);
endmodule

bind xlat_cache xlat_cache_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .linAddr(linAddr),
  .isWrite(isWrite), .userMode(userMode), .flushDir(flushDir),
  .lookupHit(lookupHit), .lookupMiss(lookupMiss), .protFault(protFault),
  .physAddr(physAddr), .attrDirty(attrDirty)
);

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;
  localparam int N_ENT = 32;
  localparam logic [1:0] OP_LOOK = 2'd0, OP_FILL = 2'd1;
  localparam logic [1:0] EX_HIT = 2'd0, EX_MISS = 2'd1, EX_FAULT = 2'd2, EX_NONE = 2'd3;
  localparam int NVEC = 17;
  // op, vpn, pfn, rw, us, dirty, write, user, expect, expected frame
  localparam logic [68:0] VEC [NVEC] = '{
    {OP_FILL, 20'h00010, 20'h0AAAA, 3'b111, 2'b00, EX_NONE,  20'h0},
    {OP_LOOK, 20'h00010, 20'h0,     3'b000, 2'b01, EX_HIT,   20'h0AAAA},
    {OP_LOOK, 20'h00010, 20'h0,     3'b000, 2'b11, EX_HIT,   20'h0AAAA},
    {OP_FILL, 20'h00020, 20'h0BBBB, 3'b011, 2'b00, EX_NONE,  20'h0},
    {OP_LOOK, 20'h00020, 20'h0,     3'b000, 2'b11, EX_FAULT, 20'h0},
    {OP_LOOK, 20'h00020, 20'h0,     3'b000, 2'b10, EX_HIT,   20'h0BBBB},
    {OP_FILL, 20'h00030, 20'h0CCCC, 3'b101, 2'b00, EX_NONE,  20'h0},
    {OP_LOOK, 20'h00030, 20'h0,     3'b000, 2'b01, EX_FAULT, 20'h0},
    {OP_LOOK, 20'h00030, 20'h0,     3'b000, 2'b00, EX_HIT,   20'h0CCCC},
    {OP_FILL, 20'h00040, 20'h0DDDD, 3'b110, 2'b00, EX_NONE,  20'h0},
    {OP_LOOK, 20'h00040, 20'h0,     3'b000, 2'b01, EX_HIT,   20'h0DDDD},
    {OP_LOOK, 20'h00040, 20'h0,     3'b000, 2'b11, EX_MISS,  20'h0},
    {OP_FILL, 20'h00040, 20'h0DDDD, 3'b111, 2'b00, EX_NONE,  20'h0},
    {OP_LOOK, 20'h00040, 20'h0,     3'b000, 2'b11, EX_HIT,   20'h0DDDD},
    {OP_LOOK, 20'h00050, 20'h0,     3'b000, 2'b00, EX_MISS,  20'h0},
    {OP_FILL, 20'h00020, 20'h0EEEE, 3'b111, 2'b00, EX_NONE,  20'h0},
    {OP_LOOK, 20'h00020, 20'h0,     3'b000, 2'b11, EX_HIT,   20'h0EEEE}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic lookupValid = 0, isWrite = 0, userMode = 0;
  logic [31:0] linAddr = '0;
  logic lookupHit, lookupMiss, protFault, attrRw, attrUs, attrDirty;
  logic [31:0] physAddr;
  logic [19:0] walkVpn;
  logic fillValid = 0, fillRw = 0, fillUs = 0, fillDirty = 0, flushDir = 0;
  logic [19:0] fillVpn = '0, fillPfn = '0;
  int nTests = 0, nFail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  xlat_cache u_dut (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .linAddr(linAddr),
    .isWrite(isWrite), .userMode(userMode), .lookupHit(lookupHit),
    .lookupMiss(lookupMiss), .protFault(protFault), .physAddr(physAddr),
    .attrRw(attrRw), .attrUs(attrUs), .attrDirty(attrDirty), .walkVpn(walkVpn),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillPfn(fillPfn),
    .fillRw(fillRw), .fillUs(fillUs), .fillDirty(fillDirty), .flushDir(flushDir)
  );

  task automatic doFill(input logic [19:0] vpn, input logic [19:0] pfn,
                        input logic [2:0] attr, input logic withFlush);
    @(negedge clk);
    lookupValid = 0;
    fillValid = 1; fillVpn = vpn; fillPfn = pfn;
    {fillRw, fillUs, fillDirty} = attr;
    flushDir = withFlush;
    @(posedge clk);
    #1 fillValid = 0; flushDir = 0;
  endtask

  task automatic doFlush();
    @(negedge clk);
    flushDir = 1;
    @(posedge clk);
    #1 flushDir = 0;
  endtask

  // lookup then check the same-cycle result; off = low address bits
  task automatic doLook(input logic [19:0] vpn, input logic wr, input logic usr,
                        input logic [1:0] ex, input logic [19:0] expPfn,
                        input string req);
    logic [31:0] expAddr;
    logic [2:0] got, want;
    @(negedge clk);
    lookupValid = 1; linAddr = {vpn, 12'h5A3}; isWrite = wr; userMode = usr;
    #1;
    nTests++;
    expAddr = (ex == EX_HIT) ? {expPfn, 12'h5A3} : 32'h0;
    got  = {lookupHit, lookupMiss, protFault};
    want = {ex == EX_HIT, ex == EX_MISS, ex == EX_FAULT};
    if (got !== want || physAddr !== expAddr || (ex == EX_MISS && walkVpn !== vpn)) begin
      nFail++;
      $display("FAIL %s vpn=%h flags hit/miss/fault got=%b exp=%b addr got=%h exp=%h walk=%h",
               req, vpn, got, want, physAddr, expAddr, walkVpn);
    end
    lookupValid = 0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 R3: empty after reset
    doLook(20'h00010, 0, 0, EX_MISS, 0, "R1");
    doLook(20'h00000, 1, 1, EX_MISS, 0, "R3");

    // table: R2 R4 R6 R7 R8 behaviour
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][68:67] == OP_FILL)
        doFill(VEC[v][66:47], VEC[v][46:27], VEC[v][26:24], 0);
      else
        doLook(VEC[v][66:47], VEC[v][23], VEC[v][22], VEC[v][21:20],
               VEC[v][19:0], "R2/R4/R6/R7/R8 table");
    end

    // R10: idle when no lookup
    @(negedge clk);
    lookupValid = 0; linAddr = {20'h00010, 12'h0};
    #1 nTests++;
    if (lookupHit || lookupMiss || protFault) begin
      nFail++;
      $display("FAIL R10 idle flags got=%b exp=000", {lookupHit, lookupMiss, protFault});
    end

    // R5: flush empties; same-cycle fill dropped
    doFlush();
    doLook(20'h00010, 0, 0, EX_MISS, 0, "R5 flush");
    doFill(20'h00060, 20'h06060, 3'b111, 1);
    doLook(20'h00060, 0, 0, EX_MISS, 0, "R5 fill dropped");

    // R8: duplicate fill overwrites, occupies one slot only
    doFlush();
    doFill(20'h00100, 20'h11111, 3'b111, 0);
    doFill(20'h00100, 20'h22222, 3'b111, 0);
    doLook(20'h00100, 0, 0, EX_HIT, 20'h22222, "R8 overwrite");
    for (int i = 0; i < N_ENT - 1; i++)
      doFill(20'h00200 + 20'(i), 20'h30000 + 20'(i), 3'b111, 0);
    doLook(20'h00100, 0, 0, EX_HIT, 20'h22222, "R8 no second slot");
    for (int i = 0; i < N_ENT - 1; i++)
      doLook(20'h00200 + 20'(i), 0, 1, EX_HIT, 20'h30000 + 20'(i), "R8 all kept");

    // R9: invalid-first then round robin from 0
    doFlush();
    for (int i = 0; i < N_ENT; i++)
      doFill(20'h00300 + 20'(i), 20'h40000 + 20'(i), 3'b111, 0);
    doFill(20'h00400, 20'h50000, 3'b111, 0);
    doLook(20'h00300, 0, 0, EX_MISS, 0, "R9 evict slot 0");
    doLook(20'h00301, 0, 0, EX_HIT, 20'h40001, "R9 slot 1 kept");
    doLook(20'h00400, 0, 0, EX_HIT, 20'h50000, "R9 new entry");
    doFill(20'h00401, 20'h50001, 3'b111, 0);
    doLook(20'h00301, 0, 0, EX_MISS, 0, "R9 evict slot 1");
    doLook(20'h00302, 0, 0, EX_HIT, 20'h40002, "R9 slot 2 kept");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule